// File: doc/BRIEF.md
# Counter Interrupt Status Register

This block collects "a counter needs attention" events from a bank of error counters and holds each one in a sticky status bit until the host services it. The bank has six counters: parity, disagreement, frame error, path parity, far-end block error and line-code violation. Each counter sends a one-cycle pulse when it rolls over or saturates. A seventh bit summarises a separate shadow status register and is set by a pulse whenever any bit of that register becomes set.

The host reads the status byte through a read strobe. The same read clears the six counter bits. The shadow summary bit survives this read. It clears only when the host reads the shadow register, and that read arrives on its own strobe.

An enable vector selects which status bits may drive a single active-high interrupt output. Status bits latch whether or not they are enabled, so a polling host still sees every event.

Top module: `ctr_irq_status`

## Requirements
- R1: After reset every status bit is 0, the interrupt output is 0 and the read data is 0x00.
- R2: A pulse on counter event line i (i = 0 parity, 1 disagreement, 2 frame error, 3 path parity, 4 far-end block error, 5 line-code violation) sets status bit i at the next clock edge.
- R3: A pulse on the shadow event input sets status bit 6. Bit 7 is reserved and always reads 0.
- R4: A status bit is set whatever the value of its enable bit. An event whose enable is 0 never raises the interrupt output.
- R5: A status read captures the status held before that edge into the read data. The data holds until the next status read. The read clears bits 0 to 5 at the same edge and leaves bit 6 unchanged.
- R6: A shadow-register read clears bit 6 at the next edge and leaves bits 0 to 5 unchanged.
- R7: When an event arrives in the same cycle as the read that would clear its bit, the bit ends up set.
- R8: The interrupt output is a register that holds the OR over bits 0 to 6 of status AND enable, as that value stood one cycle earlier. It drops one cycle after the last enabled bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctr_evt | input | 6 | Rollover/saturation pulses, one per counter |
| shadow_evt | input | 1 | Pulse when any shadow register bit sets |
| ien | input | 7 | Per-bit interrupt enables for bits 0 to 6 |
| rd_stat | input | 1 | Host read strobe for this status register |
| rd_shadow | input | 1 | Host read strobe for the shadow register |
| rd_data | output | 8 | Status byte captured by the last status read |
| irq | output | 1 | Counter interrupt output |

## Verification
The bench builds the block with its default parameters: six counter sources and an 8-bit read word. With these values every real bit position is reachable, and so is the reserved top bit. The directed scenarios drive each counter and the shadow line individually, with the enables both off and on. They also place an event in the same cycle as each kind of clearing read, and interleave the two read strobes. These cases show whether each read clears only its own bits and whether the interrupt output follows the one-cycle register delay.

// File: rtl/ctr_irq_status.sv
module ctr_irq_status #(
  parameter int N_CTR  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CTR-1:0]  ctr_evt,
  input  logic              shadow_evt,
  input  logic [N_CTR:0]    ien,
  input  logic              rd_stat,
  input  logic              rd_shadow,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int SHD  = N_CTR;
  localparam int ST_W = N_CTR + 1;

  logic [ST_W-1:0] stat, stat_nxt;

  assign stat_nxt[N_CTR-1:0] = (rd_stat ? '0 : stat[N_CTR-1:0]) | ctr_evt;
  assign stat_nxt[SHD]       = (stat[SHD] & ~rd_shadow) | shadow_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat    <= '0;
      irq     <= 1'b0;
      rd_data <= '0;
    end else begin
      stat <= stat_nxt;
      irq  <= |(stat & ien);
      if (rd_stat) rd_data <= DATA_W'(stat);
    end
  end
endmodule

module ctr_irq_status_chk #(
  parameter int N_CTR  = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_CTR-1:0]  ctr_evt,
  input logic              shadow_evt,
  input logic [N_CTR:0]    ien,
  input logic              rd_stat,
  input logic              rd_shadow,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq,
  input logic [N_CTR:0]    stat
);
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|ctr_evt) |=> ((stat[N_CTR-1:0] & $past(ctr_evt)) == $past(ctr_evt)));

  assert_shadow_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_evt |=> stat[N_CTR]);

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:N_CTR+1] == '0);

  assert_read_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> rd_data == DATA_W'($past(stat)));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && ctr_evt == '0) |=> stat[N_CTR-1:0] == '0);

  assert_read_keeps_shadow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_shadow) |=> stat[N_CTR] >= $past(stat[N_CTR]));

  assert_shadow_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_shadow && !shadow_evt) |=> !stat[N_CTR]);

  assert_shadow_read_keeps_ctr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stat) |=> ((stat[N_CTR-1:0] & $past(stat[N_CTR-1:0])) == $past(stat[N_CTR-1:0])));

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> irq == |($past(stat) & $past(ien)));
endmodule

bind ctr_irq_status ctr_irq_status_chk #(.N_CTR(N_CTR), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctr_evt(ctr_evt), .shadow_evt(shadow_evt),
  .ien(ien), .rd_stat(rd_stat), .rd_shadow(rd_shadow), .rd_data(rd_data),
  .irq(irq), .stat(stat)
);

// File: tb/tb_ctr_irq_status.sv
`timescale 1ns/1ps
module tb_ctr_irq_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] ctr_evt = '0;
  logic       shadow_evt = 1'b0;
  logic [6:0] ien = '0;
  logic       rd_stat = 1'b0;
  logic       rd_shadow = 1'b0;
  logic [7:0] rd_data;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ctr_irq_status dut (
    .clk(clk), .rst_n(rst_n), .ctr_evt(ctr_evt), .shadow_evt(shadow_evt),
    .ien(ien), .rd_stat(rd_stat), .rd_shadow(rd_shadow), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one cycle with the given strobes, then all strobes drop
  task automatic cyc(input logic [5:0] ev, input logic sh, input logic rs, input logic rsh);
    ctr_evt = ev; shadow_evt = sh; rd_stat = rs; rd_shadow = rsh;
    @(negedge clk);
    ctr_evt = '0; shadow_evt = 1'b0; rd_stat = 1'b0; rd_shadow = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    cyc('0, 1'b0, 1'b1, 1'b0);
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check(rd_data == 8'h00, "R1", rd_data, 0);
    check(irq == 1'b0, "R1", irq, 0);
    rd(v);
    check(v == 8'h00, "R1", v, 0);
  endtask

  task automatic t_sources();
    logic [7:0] v;
    ien = '0;
    for (int i = 0; i < 6; i++) begin
      cyc(6'(1 << i), 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      check(irq == 1'b0, "R4", irq, 0);
      rd(v);
      check(v == 8'(1 << i), "R2", v, 1 << i);
      rd(v);
      check(v == 8'h00, "R5", v, 0);
    end
  endtask

  task automatic t_shadow();
    logic [7:0] v;
    cyc(6'h04, 1'b1, 1'b0, 1'b0);
    rd(v);
    check(v == 8'h44, "R3", v, 8'h44);
    rd(v);
    check(v == 8'h40, "R5", v, 8'h40);
    cyc(6'h10, 1'b0, 1'b0, 1'b0);
    cyc('0, 1'b0, 1'b0, 1'b1);
    rd(v);
    check(v == 8'h10, "R6", v, 8'h10);
    check(v[7] == 1'b0, "R3", v[7], 0);
    rd(v);
    check(v == 8'h00, "R5", v, 0);
    cyc(6'h02, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check(rd_data == 8'h00, "R5", rd_data, 0);
    rd(v);
    check(v == 8'h02, "R5", v, 8'h02);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    cyc(6'h08, 1'b0, 1'b0, 1'b0);
    cyc(6'h0A, 1'b0, 1'b1, 1'b0);
    check(rd_data == 8'h08, "R7", rd_data, 8'h08);
    rd(v);
    check(v == 8'h0A, "R7", v, 8'h0A);
    cyc('0, 1'b1, 1'b0, 1'b0);
    cyc('0, 1'b1, 1'b0, 1'b1);
    rd(v);
    check(v == 8'h40, "R7", v, 8'h40);
    cyc('0, 1'b0, 1'b0, 1'b1);
    rd(v);
    check(v == 8'h00, "R6", v, 0);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    ien = 7'h04;
    cyc(6'h01, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check(irq == 1'b0, "R4", irq, 0);
    cyc(6'h04, 1'b0, 1'b0, 1'b0);
    check(irq == 1'b0, "R8", irq, 0);
    @(negedge clk);
    check(irq == 1'b1, "R8", irq, 1);
    rd(v);
    check(v == 8'h05, "R2", v, 8'h05);
    check(irq == 1'b1, "R8", irq, 1);
    @(negedge clk);
    check(irq == 1'b0, "R8", irq, 0);
    ien = 7'h40;
    cyc('0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check(irq == 1'b1, "R8", irq, 1);
    rd(v);
    @(negedge clk);
    check(irq == 1'b1, "R5", irq, 1);
    cyc('0, 1'b0, 1'b0, 1'b1);
    check(irq == 1'b1, "R8", irq, 1);
    @(negedge clk);
    check(irq == 1'b0, "R6", irq, 0);
    ien = '0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sources();
    t_shadow();
    t_collide();
    t_irq();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule